// File: doc/BRIEF.md
# 32-bit Arithmetic/Logic Unit with Status Flags

This block is the purely combinational arithmetic/logic stage of a small register-to-register core. In a single evaluation it takes two operands, the current carry bit, a small immediate, an operation code and an immediate-select line. From these it produces a result word, new zero, negative and carry values, and one write enable for each flag.

The surrounding datapath writes the result into the register file and uses the enables to merge the new flags into its status register. An operation aimed at the hard-wired zero register still drives the flag outputs, so a subtract with a discarded result works as a compare.

Addition and subtraction never read the incoming carry. Subtraction reports a borrow, not a not-borrow, on the carry output. Single-bit shifts and rotates take their carry behaviour from classic 8-bit microprocessors, and rotates pass through the carry bit.

Top module: `alu32_flags`

## Requirements
- R1: Code 0 (add) gives result = A + B modulo 2^W and carry = the unsigned carry out. It raises all three enables, and the carry input has no effect on it.
- R2: Code 1 (subtract) gives result = A - B modulo 2^W and carry = 1 exactly when B > A as unsigned numbers (a borrow). It raises all three enables, and the carry input has no effect on it.
- R3: For every defined code, zero = 1 exactly when the result is all zeros, and negative = the result's most significant bit.
- R4: Codes 2, 3 and 4 (AND, OR, XOR) give the bitwise result and raise the zero and negative enables. They hold the carry enable low and drive carry equal to the carry input.
- R5: Code 5 (shift left) gives result = A shifted up one place with 0 entering bit 0, and carry = A's top bit. It raises all three enables.
- R6: Code 6 (shift right) gives result = A shifted down one place with 0 entering the top bit, and carry = A bit 0. It drives negative = 0 with the negative enable high.
- R7: Code 7 (rotate left) puts the carry input into bit 0 and A's top bit into carry, and moves the other bits up one place. It raises all three enables.
- R8: Code 8 (rotate right) puts the carry input into the top bit and A bit 0 into carry, and moves the other bits down one place. It raises all three enables.
- R9: When the immediate select is 1, the two-operand codes 0 to 4 use the IMW-bit immediate, sign-extended to W bits, in place of B. Flags then behave exactly as with a register operand of that value.
- R10: Codes 9 to 15 are unused. They give a result of 0 and all three enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| imm_sel_i | input | 1 | 1: operand B comes from the sign-extended immediate |
| a_i | input | W | Operand A (source register, or the register updated in place) |
| b_i | input | W | Operand B (register) |
| imm_i | input | IMW | Small signed immediate |
| carry_i | input | 1 | Current carry flag |
| res_o | output | W | Result word |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| c_o | output | 1 | New carry flag (equals carry_i when not written) |
| z_we_o | output | 1 | Zero flag write enable |
| n_we_o | output | 1 | Negative flag write enable |
| c_we_o | output | 1 | Carry flag write enable |

## Verification
The interesting coincidence is a carry or borrow output arriving together with a zero result. Examples are an all-ones value plus one, and a rotate or shift that empties the word while pushing a one into carry. An exhaustive sweep of operand A, against a set of operand B values that includes 0, 1, the sign boundary and all ones, under both carry inputs, reaches these cases in a narrow configuration. Directed vectors then repeat them at full width. Each vector is judged against a bench model: the result, all three flags and all three enables must match together.

// File: rtl/alu32_flags.sv
module alu32_flags #(
  parameter int W   = 32,
  parameter int IMW = 8
) (
  input  logic [3:0]     op_i,
  input  logic           imm_sel_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [IMW-1:0] imm_i,
  input  logic           carry_i,
  output logic [W-1:0]   res_o,
  output logic           z_o,
  output logic           n_o,
  output logic           c_o,
  output logic           z_we_o,
  output logic           n_we_o,
  output logic           c_we_o
);
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_OR  = 4'd3;
  localparam logic [3:0] OP_XOR = 4'd4;
  localparam logic [3:0] OP_SHL = 4'd5;
  localparam logic [3:0] OP_SHR = 4'd6;
  localparam logic [3:0] OP_ROL = 4'd7;
  localparam logic [3:0] OP_ROR = 4'd8;
  localparam int         EXT    = W - IMW;

  logic [W-1:0] imm_ext, opb, opb_adj;
  logic [W:0]   sum;
  logic         is_sub, defined, carry_new;

  assign imm_ext = {{EXT{imm_i[IMW-1]}}, imm_i};
  assign opb     = imm_sel_i ? imm_ext : b_i;

  // one adder serves add and subtract; subtract adds the inverse plus one
  assign is_sub  = (op_i == OP_SUB);
  assign opb_adj = opb ^ {W{is_sub}};
  assign sum     = {1'b0, a_i} + {1'b0, opb_adj} + {{W{1'b0}}, is_sub};

  always_comb begin
    res_o     = '0;
    carry_new = carry_i;
    defined   = 1'b1;
    c_we_o    = 1'b1;
    unique case (op_i)
      OP_ADD: begin res_o = sum[W-1:0]; carry_new = sum[W];  end
      OP_SUB: begin res_o = sum[W-1:0]; carry_new = ~sum[W]; end
      OP_AND: begin res_o = a_i & opb;  c_we_o = 1'b0; end
      OP_OR:  begin res_o = a_i | opb;  c_we_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ opb;  c_we_o = 1'b0; end
      OP_SHL: begin res_o = {a_i[W-2:0], 1'b0};    carry_new = a_i[W-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[W-1:1]};    carry_new = a_i[0];   end
      OP_ROL: begin res_o = {a_i[W-2:0], carry_i}; carry_new = a_i[W-1]; end
      OP_ROR: begin res_o = {carry_i, a_i[W-1:1]}; carry_new = a_i[0];   end
      default: begin defined = 1'b0; c_we_o = 1'b0; end
    endcase
  end

  assign z_o    = ~|res_o;
  assign n_o    = res_o[W-1];
  assign c_o    = carry_new;
  assign z_we_o = defined;
  assign n_we_o = defined;
endmodule

module alu32_flags_chk #(
  parameter int W   = 32,
  parameter int IMW = 8
) (
  input logic [3:0]     op_i,
  input logic           imm_sel_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic [IMW-1:0] imm_i,
  input logic           carry_i,
  input logic [W-1:0]   res_o,
  input logic           z_o,
  input logic           n_o,
  input logic           c_o,
  input logic           z_we_o,
  input logic           n_we_o,
  input logic           c_we_o
);
  logic [W:0] wide_sum;
  logic       known;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
  assign known    = !$isunknown({op_i, imm_sel_i, a_i, b_i, imm_i, carry_i});

  always_comb begin
    if (known && op_i == 4'd0 && !imm_sel_i)
      p_add_sum_r1: assert ({c_o, res_o} == wide_sum && c_we_o);
    if (known && op_i == 4'd1 && !imm_sel_i)
      p_sub_borrow_r2: assert ((res_o + b_i) == a_i && c_o == (b_i > a_i));
    if (known && (op_i == 4'd2 || op_i == 4'd3 || op_i == 4'd4))
      p_logic_keeps_carry_r4: assert (!c_we_o && c_o == carry_i && z_we_o && n_we_o);
    if (known && op_i == 4'd6)
      p_shr_clears_n_r6: assert (!n_o && n_we_o && c_o == a_i[0]);
    if (known && op_i == 4'd7)
      p_rol_through_carry_r7: assert (res_o[0] == carry_i && c_o == a_i[W-1]);
    if (known && op_i > 4'd8)
      p_unused_quiet_r10: assert (!z_we_o && !n_we_o && !c_we_o && res_o == '0);
  end
endmodule

bind alu32_flags alu32_flags_chk #(.W(W), .IMW(IMW)) u_chk (
  .op_i(op_i), .imm_sel_i(imm_sel_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
  .carry_i(carry_i), .res_o(res_o), .z_o(z_o), .n_o(n_o), .c_o(c_o),
  .z_we_o(z_we_o), .n_we_o(n_we_o), .c_we_o(c_we_o)
);

// File: tb/sim_alu32_flags.sv
module sim_alu32_flags;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int TI = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]    op;
  logic          isel, cin;
  logic [TW-1:0] a, b;
  logic [TI-1:0] imm;
  logic [TW-1:0] res;
  logic          z, n, c, zwe, nwe, cwe;

  alu32_flags #(.W(TW), .IMW(TI)) u0 (
    .op_i(op), .imm_sel_i(isel), .a_i(a), .b_i(b), .imm_i(imm), .carry_i(cin),
    .res_o(res), .z_o(z), .n_o(n), .c_o(c), .z_we_o(zwe), .n_we_o(nwe), .c_we_o(cwe)
  );

  logic [3:0]  f_op;
  logic        f_isel, f_cin;
  logic [31:0] f_a, f_b, f_res;
  logic [7:0]  f_imm;
  logic        f_z, f_n, f_c, f_zwe, f_nwe, f_cwe;

  alu32_flags u1 (
    .op_i(f_op), .imm_sel_i(f_isel), .a_i(f_a), .b_i(f_b), .imm_i(f_imm), .carry_i(f_cin),
    .res_o(f_res), .z_o(f_z), .n_o(f_n), .c_o(f_c), .z_we_o(f_zwe), .n_we_o(f_nwe), .c_we_o(f_cwe)
  );

  function automatic string tag(input logic [3:0] o, input logic s);
    if (s && o <= 4'd4) return "R9";
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  // packed as {res, z, n, c, zwe, nwe, cwe}
  function automatic logic [TW+5:0] model(input logic [3:0] o, input logic s,
      input logic [TW-1:0] x, input logic [TW-1:0] y, input logic [TI-1:0] k, input logic ci);
    logic [TW-1:0] yy, r;
    logic [TW:0]   t;
    logic          co, we, cw;
    yy = s ? {{(TW-TI){k[TI-1]}}, k} : y;
    r = '0; co = ci; we = 1'b1; cw = 1'b1;
    case (o)
      4'd0: begin t = {1'b0, x} + {1'b0, yy}; r = t[TW-1:0]; co = t[TW]; end
      4'd1: begin r = x - yy; co = (x < yy); end
      4'd2: begin r = x & yy; cw = 1'b0; end
      4'd3: begin r = x | yy; cw = 1'b0; end
      4'd4: begin r = x ^ yy; cw = 1'b0; end
      4'd5: begin r = x << 1; co = x[TW-1]; end
      4'd6: begin r = x >> 1; co = x[0]; end
      4'd7: begin r = (x << 1) | {{(TW-1){1'b0}}, ci}; co = x[TW-1]; end
      4'd8: begin r = (x >> 1) | {ci, {(TW-1){1'b0}}}; co = x[0]; end
      default: begin we = 1'b0; cw = 1'b0; end
    endcase
    return {r, (r == '0), r[TW-1], co, we, we, cw};
  endfunction

  task automatic run_vec(input logic [3:0] o, input logic s, input logic [TW-1:0] x,
      input logic [TW-1:0] y, input logic [TI-1:0] k, input logic ci);
    logic [TW+5:0] exp_v, act_v;
    @(negedge clk);
    op = o; isel = s; a = x; b = y; imm = k; cin = ci;
    @(posedge clk); #1;
    exp_v = model(o, s, x, y, k, ci);
    act_v = {res, z, n, c, zwe, nwe, cwe};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d sel=%0b a=%h b=%h imm=%h cin=%0b actual=%h expected=%h",
               tag(o, s), o, s, x, y, k, ci, act_v, exp_v);
    end
  endtask

  task automatic run_wide(input string rq, input logic [3:0] o, input logic s,
      input logic [31:0] x, input logic [31:0] y, input logic [7:0] k, input logic ci,
      input logic [37:0] exp_v);
    logic [37:0] act_v;
    @(negedge clk);
    f_op = o; f_isel = s; f_a = x; f_b = y; f_imm = k; f_cin = ci;
    @(posedge clk); #1;
    act_v = {f_res, f_z, f_n, f_c, f_zwe, f_nwe, f_cwe};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s wide op=%0d actual=%h expected=%h", rq, o, act_v, exp_v);
    end
  endtask

  initial begin
    logic [TW-1:0] bset [8];
    bset[0] = 8'h00; bset[1] = 8'h01; bset[2] = 8'h7f; bset[3] = 8'h80;
    bset[4] = 8'hff; bset[5] = 8'h5a; bset[6] = 8'h33; bset[7] = 8'hc4;
    op = '0; isel = 1'b0; a = '0; b = '0; imm = '0; cin = 1'b0;
    f_op = '0; f_isel = 1'b0; f_a = '0; f_b = '0; f_imm = '0; f_cin = 1'b0;

    // idle inputs: 0 + 0 gives zero result, Z set (R1, R3)
    run_vec(4'd0, 1'b0, '0, '0, '0, 1'b0);

    // R1..R8, R10: every code against every A, several B values, both carries
    for (int o = 0; o < 16; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int bi = 0; bi < 8; bi++)
          for (int x = 0; x < 256; x++)
            run_vec(4'(o), 1'b0, TW'(x), bset[bi], '0, 1'(ci));

    // R9: immediate operand on the two-operand codes, B driven with noise
    for (int o = 0; o < 5; o++)
      for (int k = 0; k < 16; k++)
        for (int x = 0; x < 256; x++)
          run_vec(4'(o), 1'b1, TW'(x), 8'ha5, TI'(k), 1'b1);

    // full-width corners: {res, z, n, c, zwe, nwe, cwe}
    run_wide("R1", 4'd0, 1'b0, 32'hffffffff, 32'h1, 8'h0, 1'b1, {32'h0, 1'b1, 1'b0, 1'b1, 3'b111});
    run_wide("R2", 4'd1, 1'b0, 32'h0, 32'h1, 8'h0, 1'b0, {32'hffffffff, 1'b0, 1'b1, 1'b1, 3'b111});
    run_wide("R2", 4'd1, 1'b0, 32'h1234, 32'h1234, 8'h0, 1'b1, {32'h0, 1'b1, 1'b0, 1'b0, 3'b111});
    run_wide("R9", 4'd0, 1'b1, 32'h1, 32'h0, 8'hff, 1'b0, {32'h0, 1'b1, 1'b0, 1'b1, 3'b111});
    run_wide("R6", 4'd6, 1'b0, 32'h80000001, 32'h0, 8'h0, 1'b0, {32'h40000000, 1'b0, 1'b0, 1'b1, 3'b111});
    run_wide("R8", 4'd8, 1'b0, 32'h1, 32'h0, 8'h0, 1'b1, {32'h80000000, 1'b0, 1'b1, 1'b1, 3'b111});
    run_wide("R5", 4'd5, 1'b0, 32'h80000000, 32'h0, 8'h0, 1'b0, {32'h0, 1'b1, 1'b0, 1'b1, 3'b111});
    run_wide("R4", 4'd3, 1'b0, 32'h0, 32'h0, 8'h0, 1'b1, {32'h0, 1'b1, 1'b0, 1'b1, 3'b110});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule